// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management-bus slave that opens a 32-bit register file to a host that can only issue 16-bit Clause 22 MDIO frames. The register space is addressed by a 19-bit byte address. The host selects an operation mode through the two upper bits of the 5-bit PHY address field. The remaining PHY address bits and the 5-bit register number then serve as low address bits. A page register, loaded by a dedicated frame type, supplies the high address bits.

Every 32-bit register appears to the host as two 16-bit halves. A write is sent upper half first. The upper half is parked in a holding register. The lower half then commits the whole word as one 32-bit strobe, so trigger bits in the lower half act on a complete value. A read of the lower half fetches the live word and parks its upper half. A later read of the upper half returns that parked copy, so both halves come from one fetch. Frames aimed at the internal PHYs are not served here; they only raise a flag.

The MDC and MDIO pins are oversampled in the system clock domain through a synchronizer. The slave drives the data line only while it answers a read.

Top module: `mdio_paged_bridge`

## Requirements
- R1: Only frames whose start field is 01 and whose opcode is 10 (read) or 01 (write) cause any action. Any other frame produces no strobe, no flag and no drive on the data line.
- R2: PHY address bits 4:3 select the mode: 11 is page select, 10 is register access, 00 is bypass. The code 01 is ignored.
- R3: A page-select write loads write-data bits 9:0 into the page register, which then forms register address bits 18:9. The page changes at no other time.
- R4: In register mode, PHY address bits 2:0 form address bits 8:6 and the register number forms bits 5:1. Register number bit 0 (address bit 1) set selects the upper half. The word address put on `rf_addr` has bits 1:0 at zero.
- R5: A register-mode write to the upper half only loads the holding register and issues no write strobe.
- R6: A register-mode write to the lower half issues exactly one single-cycle write strobe, with data {holding register, new lower half}.
- R7: A register-mode read of the lower half issues one single-cycle read strobe. `rf_rdata` is sampled at the end of that strobe cycle. Its bits 15:0 are returned to the host and its bits 31:16 are kept in the holding register.
- R8: A register-mode read of the upper half returns the holding register, issues no read strobe, and ignores later changes in the register file.
- R9: On a served read, the slave drives 0 in the second turnaround bit, then 16 data bits MSB first. It releases the line at the end of the frame and leaves it released at all other times.
- R10: A page-select read is not answered, so the line stays released.
- R11: A valid frame in bypass mode raises `pass_hit` for one cycle and issues no register strobe and no drive.
- R12: Reset clears the page register and the holding register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples MDC |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management bus clock from the host |
| mdio_i | input | 1 | Sampled value of the bidirectional data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| rf_rd | output | 1 | Single-cycle read strobe to the register file |
| rf_wr | output | 1 | Single-cycle write strobe to the register file |
| rf_addr | output | 19 | Word-aligned byte address for the strobes |
| rf_wdata | output | 32 | Write data accompanying `rf_wr` |
| rf_rdata | input | 32 | Read data, sampled at the end of the `rf_rd` cycle |
| pass_hit | output | 1 | Pulse for a frame addressed to the internal PHYs |

## Verification
Header-driven results (`rf_rd`, `pass_hit`) appear four system clocks after the MDC rising edge that carries the 14th frame bit: two synchronizer stages, the edge detector, then the decode register. `rf_wr` appears the same distance after the 32nd bit. The host model holds each MDC phase for eight clocks. Strobes are logged at falling clock edges and checked only after eight idle clocks at the end of a frame, so every strobe has landed before its check. Driven bits change about four clocks after an MDC fall. The bench samples the line in the last clock before MDC rises, and checks that drive is released eight clocks after the final rising edge.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_REG    = 2'b10,
    MODE_PAGE   = 2'b11
  } bridge_mode_e;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OPC_READ   = 2'b10;
  localparam logic [1:0] OPC_WRITE  = 2'b01;

  localparam int HDR_BITS   = 14;
  localparam int FRAME_BITS = 32;
  localparam int HALF_W     = 16;

  typedef struct packed {
    logic [1:0] start;
    logic [1:0] opc;
    logic [4:0] phy;
    logic [4:0] regnum;
  } mdio_hdr_t;

  function automatic bridge_mode_e hdr_mode(mdio_hdr_t h);
    return bridge_mode_e'(h.phy[4:3]);
  endfunction

  function automatic logic hdr_valid(mdio_hdr_t h);
    return (h.start == START_CODE) && ((h.opc == OPC_READ) || (h.opc == OPC_WRITE));
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_s
);
  logic [SYNC_STAGES:0]   mdc_q;
  logic [SYNC_STAGES-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[SYNC_STAGES-1:0], mdc};
      dat_q <= {dat_q[SYNC_STAGES-2:0], mdio_i};
    end
  end

  assign mdc_rise = mdc_q[SYNC_STAGES-1] & ~mdc_q[SYNC_STAGES];
  assign mdc_fall = ~mdc_q[SYNC_STAGES-1] & mdc_q[SYNC_STAGES];
  assign mdio_s   = dat_q[SYNC_STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mdc_rise,
  input  logic             mdc_fall,
  input  logic             mdio_s,
  input  logic             resp_en,
  input  logic [HALF_W-1:0] tx_word,
  output mdio_hdr_t        hdr,
  output logic             hdr_evt,
  output logic             frame_end,
  output logic [HALF_W-1:0] rx_data,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             active;
  logic [CNT_W-1:0] bitn;
  logic [HALF_W-1:0] sreg, sreg_nx, txsh;

  assign sreg_nx = {sreg[HALF_W-2:0], mdio_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bitn      <= '0;
      sreg      <= '1;
      hdr       <= '0;
      hdr_evt   <= 1'b0;
      frame_end <= 1'b0;
      rx_data   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      txsh      <= '0;
    end else begin
      hdr_evt   <= 1'b0;
      frame_end <= 1'b0;
      if (mdc_rise) begin
        sreg <= sreg_nx;
        if (!active) begin
          if (!mdio_s) begin
            active <= 1'b1;
            bitn   <= CNT_W'(1);
          end
        end else begin
          bitn <= bitn + 1'b1;
          if (bitn == CNT_W'(HDR_BITS - 1)) begin
            hdr     <= mdio_hdr_t'(sreg_nx[HDR_BITS-1:0]);
            hdr_evt <= 1'b1;
          end
          if (bitn == CNT_W'(FRAME_BITS - 1)) begin
            rx_data   <= sreg_nx;
            frame_end <= 1'b1;
            active    <= 1'b0;
            mdio_oe   <= 1'b0;
          end
        end
      end else if (mdc_fall && active && resp_en) begin
        if (bitn == CNT_W'(HDR_BITS + 1)) begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
          txsh    <= tx_word;
        end else if (bitn > CNT_W'(HDR_BITS + 1)) begin
          mdio_o <= txsh[HALF_W-1];
          txsh   <= {txsh[HALF_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_ta_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  assert_drive_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> resp_en);
  assert_drive_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> active);
endmodule

// File: rtl/paged_reg_port.sv
module paged_reg_port
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int AW    = PAGE_W + 9,
  localparam int DW    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mdio_hdr_t         hdr,
  input  logic              hdr_evt,
  input  logic              frame_end,
  input  logic [HALF_W-1:0] rx_data,
  input  logic [DW-1:0]     rf_rdata,
  output logic              resp_en,
  output logic [HALF_W-1:0] tx_word,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic [AW-1:0]     rf_addr,
  output logic [DW-1:0]     rf_wdata,
  output logic              pass_hit
);
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] hold;

  function automatic logic [AW-1:0] word_addr(logic [PAGE_W-1:0] pg, mdio_hdr_t h);
    return {pg, h.phy[2:0], h.regnum[4:1], 2'b00};
  endfunction

  wire upper = hdr.regnum[0];
  wire ok    = hdr_valid(hdr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page     <= '0;
      hold     <= '0;
      resp_en  <= 1'b0;
      tx_word  <= '0;
      rf_rd    <= 1'b0;
      rf_wr    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      pass_hit <= 1'b0;
    end else begin
      rf_rd    <= 1'b0;
      rf_wr    <= 1'b0;
      pass_hit <= 1'b0;
      if (rf_rd) begin
        tx_word <= rf_rdata[HALF_W-1:0];
        hold    <= rf_rdata[DW-1:HALF_W];
      end
      if (hdr_evt) begin
        resp_en <= 1'b0;
        if (ok) begin
          case (hdr_mode(hdr))
            MODE_BYPASS: pass_hit <= 1'b1;
            MODE_REG: if (hdr.opc == OPC_READ) begin
              resp_en <= 1'b1;
              if (upper) tx_word <= hold;
              else begin
                rf_rd   <= 1'b1;
                rf_addr <= word_addr(page, hdr);
              end
            end
            default: ;
          endcase
        end
      end
      if (frame_end && ok && hdr.opc == OPC_WRITE) begin
        case (hdr_mode(hdr))
          MODE_PAGE: page <= rx_data[PAGE_W-1:0];
          MODE_REG: if (upper) hold <= rx_data;
            else begin
              rf_wr    <= 1'b1;
              rf_wdata <= {hold, rx_data};
              rf_addr  <= word_addr(page, hdr);
            end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd && rf_wr));
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);
  assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |=> !rf_rd);
  assert_page_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(page));
  assert_pass_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pass_hit |-> !(rf_rd || rf_wr));
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = PAGE_W + 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          rf_rd,
  output logic          rf_wr,
  output logic [AW-1:0] rf_addr,
  output logic [31:0]   rf_wdata,
  input  logic [31:0]   rf_rdata,
  output logic          pass_hit
);
  logic              mdc_rise, mdc_fall, mdio_s;
  logic              hdr_evt, frame_end, resp_en;
  logic [HALF_W-1:0] rx_data, tx_word;
  mdio_hdr_t         hdr;

  mdio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
    .mdc_rise(mdc_rise), .mdc_fall(mdc_fall), .mdio_s(mdio_s));

  mdio_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall),
    .mdio_s(mdio_s), .resp_en(resp_en), .tx_word(tx_word), .hdr(hdr),
    .hdr_evt(hdr_evt), .frame_end(frame_end), .rx_data(rx_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  paged_reg_port #(.PAGE_W(PAGE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .hdr(hdr), .hdr_evt(hdr_evt),
    .frame_end(frame_end), .rx_data(rx_data), .rf_rdata(rf_rdata),
    .resp_en(resp_en), .tx_word(tx_word), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .pass_hit(pass_hit));
endmodule

// File: tb/test_mdio_paged_bridge.sv
`timescale 1ns/1ps
module test_mdio_paged_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic m_drv = 1'b1;
  logic m_bit = 1'b1;
  logic [31:0] key = 32'h0;
  wire  bus_line;
  logic mdio_o, mdio_oe, rf_rd, rf_wr, pass_hit;
  logic [18:0] rf_addr;
  logic [31:0] rf_wdata, rf_rdata;

  int vec = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, byp_cnt = 0, oe_cycles = 0;
  logic [18:0] last_wa, last_ra;
  logic [31:0] last_wd;

  always #2 clk = ~clk;

  assign bus_line = mdio_oe ? mdio_o : (m_drv ? m_bit : 1'b1);
  assign rf_rdata = {13'h1ACE, rf_addr} ^ key;

  mdio_paged_bridge i_mdio_paged_bridge (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(bus_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .pass_hit(pass_hit));

  always @(negedge clk) if (rst_n) begin
    if (rf_wr) begin wr_cnt++; last_wa = rf_addr; last_wd = rf_wdata; end
    if (rf_rd) begin rd_cnt++; last_ra = rf_addr; end
    if (pass_hit) byp_cnt++;
    if (mdio_oe) oe_cycles++;
  end

  function automatic logic [18:0] exp_addr(logic [9:0] pg, logic [2:0] p3, logic [4:0] rg);
    return 19'((int'(pg) << 9) + (int'(p3) << 6) + ((int'(rg) & 30) << 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic b, input logic drv, output logic s);
    m_drv = drv; m_bit = b; mdc = 1'b0;
    repeat (8) @(negedge clk);
    s = bus_line; mdc = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd,
                       output logic [15:0] rd16, output logic ta2, output logic drove);
    logic s;
    logic [13:0] hb;
    int oe0;
    hb = {st, op, phy, rg};
    oe0 = oe_cycles;
    for (int i = 0; i < 32; i++) mbit(1'b1, 1'b1, s);
    for (int i = 13; i >= 0; i--) mbit(hb[i], 1'b1, s);
    if (op == 2'b10) begin
      mbit(1'b1, 1'b0, s);
      mbit(1'b1, 1'b0, ta2);
      for (int i = 15; i >= 0; i--) begin mbit(1'b1, 1'b0, s); rd16[i] = s; end
    end else begin
      mbit(1'b1, 1'b1, s);
      mbit(1'b0, 1'b1, s);
      ta2 = 1'b1; rd16 = 16'hFFFF;
      for (int i = 15; i >= 0; i--) mbit(wd[i], 1'b1, s);
    end
    m_drv = 1'b1; m_bit = 1'b1;
    repeat (8) @(negedge clk);
    drove = (oe_cycles != oe0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  logic [15:0] r16; logic ta, dr;
  int w0, r0, b0;

  task automatic t_reset();
    do_reset();
    chk("R12 oe after reset", 32'(mdio_oe), 0);
    frame(2'b01, 2'b10, 5'b10000, 5'b00001, 16'h0, r16, ta, dr);
    chk("R12 hold cleared", 32'(r16), 32'h0);
    chk("R8 no strobe on upper read", 32'(rd_cnt), 0);
  endtask

  task automatic t_page();
    frame(2'b01, 2'b01, 5'b11000, 5'b00000, 16'hF2B5, r16, ta, dr);
    chk("R3 page write no strobe", 32'(wr_cnt), 0);
    frame(2'b01, 2'b10, 5'b11000, 5'b00000, 16'h0, r16, ta, dr);
    chk("R10 page read released", 32'(dr), 0);
    chk("R10 page read data", 32'(r16), 32'hFFFF);
  endtask

  task automatic t_low_read();
    logic [18:0] a;
    r0 = rd_cnt; key = 32'h0;
    a = exp_addr(10'h2B5, 3'b011, 5'b01010);
    frame(2'b01, 2'b10, 5'b10011, 5'b01010, 16'h0, r16, ta, dr);
    chk("R7 one read strobe", 32'(rd_cnt - r0), 1);
    chk("R4 R3 read address", 32'(last_ra), 32'(a));
    chk("R7 low half data", 32'(r16), 32'({13'h1ACE, a} & 32'hFFFF));
    chk("R9 turnaround low", 32'(ta), 0);
    chk("R9 released after frame", 32'(mdio_oe), 0);
  endtask

  task automatic t_upper_read();
    logic [18:0] a;
    r0 = rd_cnt;
    a = exp_addr(10'h2B5, 3'b011, 5'b01010);
    key = 32'hFFFF0000;
    frame(2'b01, 2'b10, 5'b10011, 5'b01011, 16'h0, r16, ta, dr);
    chk("R8 upper from snapshot", 32'(r16), 32'({13'h1ACE, a} >> 16));
    chk("R8 no read strobe", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_write_pair();
    w0 = wr_cnt;
    frame(2'b01, 2'b01, 5'b10101, 5'b00111, 16'hBEEF, r16, ta, dr);
    chk("R5 upper write no strobe", 32'(wr_cnt - w0), 0);
    frame(2'b01, 2'b01, 5'b10101, 5'b00110, 16'h1234, r16, ta, dr);
    chk("R6 one write strobe", 32'(wr_cnt - w0), 1);
    chk("R6 combined data", last_wd, 32'hBEEF1234);
    chk("R4 write address", 32'(last_wa), 32'(exp_addr(10'h2B5, 3'b101, 5'b00110)));
    chk("R1 write never drives", 32'(dr), 0);
  endtask

  task automatic t_bypass();
    w0 = wr_cnt; r0 = rd_cnt; b0 = byp_cnt;
    frame(2'b01, 2'b01, 5'b00010, 5'b00100, 16'h5555, r16, ta, dr);
    frame(2'b01, 2'b10, 5'b00010, 5'b00100, 16'h0, r16, ta, dr);
    chk("R11 two flags", 32'(byp_cnt - b0), 2);
    chk("R11 no strobes", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
    chk("R11 no drive", 32'(dr), 0);
  endtask

  task automatic t_bad();
    w0 = wr_cnt; r0 = rd_cnt; b0 = byp_cnt;
    frame(2'b01, 2'b11, 5'b10000, 5'b00010, 16'hAAAA, r16, ta, dr);
    frame(2'b00, 2'b01, 5'b10000, 5'b00010, 16'hAAAA, r16, ta, dr);
    chk("R1 bad opcode or start ignored", 32'(wr_cnt - w0), 0);
    frame(2'b01, 2'b01, 5'b01000, 5'b00010, 16'hAAAA, r16, ta, dr);
    frame(2'b01, 2'b10, 5'b01000, 5'b00010, 16'h0, r16, ta, dr);
    chk("R2 mode 01 ignored", 32'(wr_cnt - w0 + rd_cnt - r0 + byp_cnt - b0), 0);
    chk("R2 mode 01 no drive", 32'(dr), 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    r0 = rd_cnt; key = 32'h0;
    frame(2'b01, 2'b10, 5'b10000, 5'b00011, 16'h0, r16, ta, dr);
    chk("R12 hold zero after reset", 32'(r16), 0);
    frame(2'b01, 2'b10, 5'b10001, 5'b00100, 16'h0, r16, ta, dr);
    chk("R12 page zero after reset", 32'(last_ra), 32'(exp_addr(10'h0, 3'b001, 5'b00100)));
    chk("R7 one strobe", 32'(rd_cnt - r0), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_page();
    t_low_read();
    t_upper_read();
    t_write_pair();
    t_bypass();
    t_bad();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule